// File: doc/BRIEF.md
# Prescaled Reload Timeout Timer

This block is a one-shot timeout timer for a contactless reader front end. A programmable prescaler divides the reader clock so that one timer tick occurs every 2·P + 1 clock cycles, where P is a 12-bit value. A 16-bit down-counter is loaded from a reload value and steps down once per tick. When it reaches zero it raises a sticky interrupt flag, which the command logic reads as "no response arrived in time". The flag stays set until software clears it by writing one.

Software programs four byte-wide configuration registers through a simple write port. The timer is armed by an explicit start pulse. When auto-start is enabled it is also armed by the end of every transmission, so the receive window opens without software involvement. A stop pulse halts it, and so does the beginning of a reception, so a response that is already arriving is not cut off by a late expiry.

The controller has three states. IDLE means stopped and not expired. RUN means counting. DONE means expired.

- An arm event moves any state to RUN.
- A halt event moves any state to IDLE.
- A tick in RUN with the count at 1 or 0 moves the controller to DONE. This is the expire transition.
- Every other tick in RUN stays in RUN and decrements the count.

Top module: `tmo_timer`

## Requirements
- R1: After reset `running` is 0, `irq_flag` is 0 and `count_val` is 0.
- R2: Configuration writes use `cfg_addr` as follows:
  - Address 0 is the mode byte. Bit 7 is auto-start enable and bits 3:0 are P[11:8].
  - Address 1 is P[7:0].
  - Address 2 is reload[15:8].
  - Address 3 is reload[7:0].
- R3: A start pulse with no halt loads `count_val` with the reload value and sets `running` on the following clock edge.
- R4: While running, `count_val` decrements once every 2·P + 1 clock cycles. The first decrement comes 2·P + 1 cycles after the load.
- R5: When the count goes from 1 to 0 on a tick, `irq_flag` is set, `running` drops and the count stays at 0. A reload value of 0 expires on the first tick, in the same way as a reload of 1.
- R6: With auto-start enabled, a `tx_done` pulse arms the timer exactly as start does. With auto-start disabled, `tx_done` has no effect: `running` stays 0 and the count is unchanged.
- R7: An arm event while running reloads the counter and restarts the prescaler from zero. An arm event in the same cycle as a pending expiry tick wins, and no interrupt is raised.
- R8: A `stop` or `rx_begin` pulse halts the timer with the count held, and no interrupt follows. A halt in the same cycle as an arm event wins.
- R9: `irq_flag` is sticky until `irq_w1c` is 1. When an expiry and a clear fall in the same cycle, the flag ends set.
- R10: After expiry the timer can be re-armed. The interrupt flag is left untouched by the re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reader clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| start | input | 1 | Software arm pulse |
| stop | input | 1 | Software halt pulse |
| tx_done | input | 1 | End-of-transmission pulse (auto-start source) |
| rx_begin | input | 1 | Start-of-reception pulse (halts the timer) |
| irq_w1c | input | 1 | Write-one-to-clear for the interrupt flag |
| running | output | 1 | Timer is counting (RUN state) |
| count_val | output | 16 | Current counter value |
| irq_flag | output | 1 | Sticky timeout interrupt flag |

## Verification
The expiry that sets the interrupt flag and a software write-one-to-clear can land on the same clock edge. With P = 0 and reload 2, the bench holds the clear asserted across the edge on which the count reaches zero, and then checks that the flag reads 1. A second collision, a restart on the exact edge of the final tick, is provoked with P = 0 and reload 1. It is judged by the absence of the flag and by a count that is freshly reloaded. All expected counts, states and flag values are computed from 2·P + 1 and the reload value over a sweep of small prescaler settings, one of which also exercises the high nibble, and reload values.

// File: rtl/tmo_timer_pkg.sv
package tmo_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tmo_state_e;

    localparam logic [1:0] ADDR_MODE   = 2'd0;
    localparam logic [1:0] ADDR_PRE_LO = 2'd1;
    localparam logic [1:0] ADDR_RLD_HI = 2'd2;
    localparam logic [1:0] ADDR_RLD_LO = 2'd3;

    localparam int AUTO_BIT = 7;

endpackage

// File: rtl/tmo_cfg_regs.sv
module tmo_cfg_regs
    import tmo_timer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 12,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              auto_en,
    output logic [PRE_W-1:0]  pre_val,
    output logic [CNT_W-1:0]  reload_val
);

    localparam int PRE_HI_W = PRE_W - DATA_W;
    localparam int RLD_HI_W = CNT_W - DATA_W;

    logic                auto_q;
    logic [PRE_HI_W-1:0] pre_hi_q;
    logic [DATA_W-1:0]   pre_lo_q;
    logic [RLD_HI_W-1:0] rld_hi_q;
    logic [DATA_W-1:0]   rld_lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q   <= 1'b0;
            pre_hi_q <= '0;
            pre_lo_q <= '0;
            rld_hi_q <= '0;
            rld_lo_q <= '0;
        end else if (cfg_wr) begin
            unique case (cfg_addr)
                ADDR_MODE: begin
                    auto_q   <= cfg_wdata[AUTO_BIT];
                    pre_hi_q <= cfg_wdata[PRE_HI_W-1:0];
                end
                ADDR_PRE_LO: pre_lo_q <= cfg_wdata;
                ADDR_RLD_HI: rld_hi_q <= cfg_wdata[RLD_HI_W-1:0];
                ADDR_RLD_LO: rld_lo_q <= cfg_wdata;
                default: ;
            endcase
        end
    end

    assign auto_en    = auto_q;
    assign pre_val    = {pre_hi_q, pre_lo_q};
    assign reload_val = {rld_hi_q, rld_lo_q};

endmodule

// File: rtl/tmo_prescaler.sv
module tmo_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic [PRE_W-1:0] pre_val,
    output logic             tick
);

    localparam int PC_W = PRE_W + 1;

    logic [PC_W-1:0] pcnt_q;
    logic [PC_W-1:0] limit;
    logic            at_limit;

    // One tick per 2*P+1 cycles: count 0..2P inclusive.
    assign limit    = {pre_val, 1'b0};
    assign at_limit = (pcnt_q >= limit);
    assign tick     = enable && at_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clear) begin
            pcnt_q <= '0;
        end else if (enable) begin
            if (at_limit) begin
                pcnt_q <= '0;
            end else begin
                pcnt_q <= pcnt_q + PC_W'(1);
            end
        end
    end

endmodule

// File: rtl/tmo_count_fsm.sv
module tmo_count_fsm
    import tmo_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             halt,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_val,
    output logic             running,
    output logic             expire,
    output logic             pre_clear,
    output logic [CNT_W-1:0] count_val
);

    tmo_state_e       state_q;
    tmo_state_e       state_d;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;

    // State and count register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // Transitions and outputs. Halt beats arm, and arm beats tick.
    always_comb begin
        state_d   = state_q;
        count_d   = count_q;
        expire    = 1'b0;
        pre_clear = 1'b0;
        if (halt) begin
            state_d   = ST_IDLE;
            pre_clear = 1'b1;
        end else if (arm) begin
            state_d   = ST_RUN;
            count_d   = reload_val;
            pre_clear = 1'b1;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (tick) begin
                        if (count_q <= CNT_W'(1)) begin
                            count_d = '0;
                            state_d = ST_DONE;
                            expire  = 1'b1;
                        end else begin
                            count_d = count_q - CNT_W'(1);
                        end
                    end
                end
                ST_IDLE, ST_DONE: begin
                    state_d = state_q;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    assign running   = (state_q == ST_RUN);
    assign count_val = count_q;

endmodule

// File: rtl/tmo_irq_flag.sv
module tmo_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_w1c,
    output logic flag
);

    // Setting wins over a same-cycle clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr_w1c) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tmo_timer.sv
module tmo_timer #(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 12,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              start,
    input  logic              stop,
    input  logic              tx_done,
    input  logic              rx_begin,
    input  logic              irq_w1c,
    output logic              running,
    output logic [CNT_W-1:0]  count_val,
    output logic              irq_flag
);

    logic             auto_en;
    logic [PRE_W-1:0] pre_val;
    logic [CNT_W-1:0] reload_val;
    logic             arm;
    logic             halt;
    logic             tick;
    logic             expire;
    logic             pre_clear;

    assign arm  = start || (auto_en && tx_done);
    assign halt = stop || rx_begin;

    tmo_cfg_regs #(
        .DATA_W (DATA_W),
        .PRE_W  (PRE_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .auto_en    (auto_en),
        .pre_val    (pre_val),
        .reload_val (reload_val)
    );

    tmo_prescaler #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pre_clear),
        .enable  (running),
        .pre_val (pre_val),
        .tick    (tick)
    );

    tmo_count_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .halt       (halt),
        .tick       (tick),
        .reload_val (reload_val),
        .running    (running),
        .expire     (expire),
        .pre_clear  (pre_clear),
        .count_val  (count_val)
    );

    tmo_irq_flag u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (expire),
        .clr_w1c (irq_w1c),
        .flag    (irq_flag)
    );

endmodule

// File: rtl/tmo_timer_checker.sv
module tmo_timer_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             stop,
    input logic             tx_done,
    input logic             rx_begin,
    input logic             irq_w1c,
    input logic             auto_en,
    input logic             arm,
    input logic             tick,
    input logic             expire,
    input logic [CNT_W-1:0] reload_val,
    input logic             running,
    input logic [CNT_W-1:0] count_val,
    input logic             irq_flag
);

    assert_start_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop && !rx_begin) |=> (running && count_val == $past(reload_val)));

    assert_count_only_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !arm) |=> $stable(count_val));

    assert_expire_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (irq_flag && !running && count_val == '0));

    assert_tx_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start && !(auto_en && tx_done)) |=> !running);

    assert_halt_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop || rx_begin) |=> !running);

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_w1c) |=> irq_flag);

endmodule

bind tmo_timer tmo_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .stop       (stop),
    .tx_done    (tx_done),
    .rx_begin   (rx_begin),
    .irq_w1c    (irq_w1c),
    .auto_en    (auto_en),
    .arm        (arm),
    .tick       (tick),
    .expire     (expire),
    .reload_val (reload_val),
    .running    (running),
    .count_val  (count_val),
    .irq_flag   (irq_flag)
);

// File: tb/tmo_timer_test.sv
`timescale 1ns/1ps
module tmo_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        tx_done = 1'b0;
    logic        rx_begin = 1'b0;
    logic        irq_w1c = 1'b0;
    logic        running;
    logic [15:0] count_val;
    logic        irq_flag;

    int checks = 0;
    int failures = 0;

    int pv [0:4] = '{0, 1, 2, 5, 257};

    always #4 clk = ~clk;

    tmo_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .start     (start),
        .stop      (stop),
        .tx_done   (tx_done),
        .rx_begin  (rx_begin),
        .irq_w1c   (irq_w1c),
        .running   (running),
        .count_val (count_val),
        .irq_flag  (irq_flag)
    );

    task automatic chk(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", what, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic setup(input int p, input int r, input logic au);
        wr(2'd0, {au, 3'b000, 4'(p >> 8)});
        wr(2'd1, 8'(p));
        wr(2'd2, 8'(r >> 8));
        wr(2'd3, 8'(r));
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1; @(negedge clk); stop = 1'b0;
    endtask

    task automatic pulse_tx();
        tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic clr_irq();
        irq_w1c = 1'b1; @(negedge clk); irq_w1c = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R1..R10 watchdog got=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 running after reset", int'(running), 0);
        chk("R1 irq after reset", int'(irq_flag), 0);
        chk("R1 count after reset", int'(count_val), 0);

        // Sweep of prescaler and reload values.
        foreach (pv[i]) begin
            for (int r = 0; r < 4; r++) begin
                int per;
                int eff;
                per = 2 * pv[i] + 1;
                eff = (r == 0) ? 1 : r;
                setup(pv[i], r, 1'b0);
                pulse_start();
                for (int t = 0; t <= eff * per; t++) begin
                    int ec;
                    ec = (r == 0) ? 0 : (r - t / per);
                    if (t == 0)
                        chk("R3 load count", int'(count_val), ec);
                    else if (t == eff * per)
                        chk("R5 count at expiry", int'(count_val), 0);
                    else
                        chk("R2/R4 count step", int'(count_val), ec);
                    chk("R4/R5 running", int'(running), (t < eff * per) ? 1 : 0);
                    chk("R5 irq", int'(irq_flag), (t >= eff * per) ? 1 : 0);
                    @(negedge clk);
                end
                chk("R5 count held after expiry", int'(count_val), 0);
                chk("R9 irq sticky", int'(irq_flag), 1);
                clr_irq();
                chk("R9 irq cleared", int'(irq_flag), 0);
            end
        end

        // Restart while running resets the prescaler too.
        setup(2, 5, 1'b0);
        pulse_start();
        repeat (7) @(negedge clk);
        chk("R4 count before restart", int'(count_val), 4);
        pulse_start();
        chk("R7 reload on restart", int'(count_val), 5);
        repeat (4) @(negedge clk);
        chk("R7 prescaler restarted", int'(count_val), 5);
        @(negedge clk);
        chk("R7 first tick after restart", int'(count_val), 4);

        // Halt by stop and by rx_begin.
        setup(1, 4, 1'b0);
        pulse_start();
        repeat (4) @(negedge clk);
        pulse_stop();
        chk("R8 stop halts", int'(running), 0);
        chk("R8 count held", int'(count_val), 3);
        repeat (30) @(negedge clk);
        chk("R8 no irq after stop", int'(irq_flag), 0);
        chk("R8 count still held", int'(count_val), 3);
        pulse_start();
        repeat (2) @(negedge clk);
        rx_begin = 1'b1; @(negedge clk); rx_begin = 1'b0;
        chk("R8 rx_begin halts", int'(running), 0);
        repeat (20) @(negedge clk);
        chk("R8 no irq after rx_begin", int'(irq_flag), 0);
        start = 1'b1; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk("R8 halt beats arm", int'(running), 0);

        // Expiry and clear in the same cycle.
        setup(0, 2, 1'b0);
        pulse_start();
        irq_w1c = 1'b1;
        @(negedge clk);
        @(negedge clk);
        irq_w1c = 1'b0;
        chk("R9 set beats clear", int'(irq_flag), 1);
        repeat (5) @(negedge clk);
        chk("R9 still set", int'(irq_flag), 1);
        clr_irq();
        chk("R9 cleared by w1c", int'(irq_flag), 0);

        // Arm on the edge of the final tick.
        setup(0, 1, 1'b0);
        pulse_start();
        pulse_start();
        chk("R7 arm beats expiry irq", int'(irq_flag), 0);
        chk("R7 arm beats expiry running", int'(running), 1);
        chk("R7 arm beats expiry count", int'(count_val), 1);
        @(negedge clk);
        chk("R5 expiry after re-arm", int'(irq_flag), 1);

        // Auto-start.
        clr_irq();
        setup(0, 3, 1'b1);
        pulse_tx();
        chk("R6 auto arm running", int'(running), 1);
        chk("R6 auto arm count", int'(count_val), 3);
        repeat (3) @(negedge clk);
        chk("R6 auto expiry irq", int'(irq_flag), 1);
        pulse_tx();
        chk("R10 re-arm after expiry", int'(running), 1);
        chk("R10 irq untouched by re-arm", int'(irq_flag), 1);
        pulse_stop();
        chk("R8 stop after auto arm", int'(count_val), 3);
        setup(0, 9, 1'b0);
        pulse_tx();
        chk("R6 tx ignored running", int'(running), 0);
        chk("R6 tx ignored count", int'(count_val), 3);
        clr_irq();
        chk("R9 final clear", int'(irq_flag), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule